// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer load and inspect the program memory and the data EEPROM of a small controller. It works only while the device reset pin is held low. The programmer clocks 32-bit instructions in on a serial clock and data line, and gets a reply on a serial output line. Each instruction is four bytes long. The block decodes the first byte, and sometimes the second byte, to choose one of these operations: session enable, chip erase, lock setting, program-word byte read or write, or EEPROM byte read or write.

The two memories are plain internal arrays. The program memory is PMEM_DEPTH words of 16 bits and the data EEPROM is EE_DEPTH bytes. A write holds the block busy for a fixed number of system clocks. A chip erase holds it busy while it fills every location with ones, one address per clock. A lock level can be raised that blocks writes, or blocks both writes and read-back. Only a chip erase lowers it again.

The serial clock is oversampled by the system clock, so the serial clock must run well below the system clock (eight or more system clocks per half period).

Top module: `isp_prog_slave`

## Requirements
- R1: While the device reset pin is high, the serial output stays low and serial clock edges are ignored. A session opens once the reset pin and the serial clock have both been seen low.
- R2: Serial transfer is mode 0. Input is sampled on the rising serial clock edge, the output changes after the falling edge, most significant bit first, and every 32 rising edges form one instruction.
- R3: Instruction AC 53 xx xx enables programming. For every instruction, the third reply byte repeats the second byte received (0x53 for the enable).
- R4: Before the enable, every other instruction has no effect and the fourth reply byte is 0x00.
- R5: Program memory byte access. First byte 0010_H000 reads and 0100_H000 writes. The word address is {byte2[1:0], byte3}. H=1 selects bits 15:8 and H=0 selects bits 7:0. Byte 4 carries the write data, and the fourth reply byte carries the read data.
- R6: EEPROM access. First byte 0xA0 reads and 0xC0 writes. The address is byte3[6:0], byte 2 is ignored, and the data uses byte 4 as in R5.
- R7: After an accepted write the block is busy for WR_BUSY system clocks. A write, erase or lock instruction that completes in that window is ignored.
- R8: Instruction AC 100x_xxxx performs a chip erase. It sets every program word to 0xFFFF and every EEPROM byte to 0xFF, and it resets the lock level to open.
- R9: Instruction AC 111x_xxLV sets the lock level. V=1 with L=0 blocks programming; L=1 blocks programming and verify. The level only rises, and a request for a lower level has no effect.
- R10: While any lock is set, writes are ignored. With the programming-only lock, reads still return memory contents.
- R11: With the full lock, every read returns 0xFF.
- R12: Raising the device reset pin ends the session, and a new session needs a fresh enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prog_rst_n | input | 1 | Device reset pin; programming happens while it is low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial instruction data from the programmer |
| miso | output | 1 | Serial reply data to the programmer |

## Verification
A wrong bit or byte count shows up within one instruction: the third reply byte stops echoing the second byte, and read-back data comes out shifted. A wrong enable or lock state becomes visible in the next read. That read returns 0x00, 0xFF or stale data where the requirements expect memory contents, or a write fails to change what a later read returns. A wrong busy or erase window is seen by issuing a write straight after a write or an erase and reading both addresses back.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_CTRL     = 8'hAC;
  localparam logic [7:0] KEY_ENABLE  = 8'h53;
  localparam logic [6:0] OP_PM_RD    = 7'b0010_000;  // first byte without H bit
  localparam logic [6:0] OP_PM_WR    = 7'b0100_000;
  localparam logic [7:0] OP_EE_RD    = 8'hA0;
  localparam logic [7:0] OP_EE_WR    = 8'hC0;
  localparam logic [2:0] SUB_ERASE   = 3'b100;
  localparam logic [2:0] SUB_LOCK    = 3'b111;

  typedef enum logic [1:0] {
    LK_OPEN     = 2'd0,
    LK_NOPROG   = 2'd1,
    LK_NOVERIFY = 2'd2
  } lock_e;
endpackage

// File: rtl/isp_edge_sync.sv
module isp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic prog_rst_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic session
);
  localparam int STAGES = 2;
  localparam logic [1:0] RST_VAL = 2'b10;  // bit1: reset pin, bit0: sck

  logic [1:0] stg [STAGES];
  logic       sck_d, sck_d_nxt;
  logic       sess_nxt;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= {prog_rst_n, sck};
      else         stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  always_comb begin
    sck_d_nxt = stg[STAGES-1][0];
    sess_nxt  = session;
    if (stg[STAGES-1][1])                        sess_nxt = 1'b0;
    else if (!stg[STAGES-1][0])                  sess_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      session <= 1'b0;
    end else begin
      sck_d   <= sck_d_nxt;
      session <= sess_nxt;
    end
  end

  assign sck_rise = session &&  stg[STAGES-1][0] && !sck_d;
  assign sck_fall = session && !stg[STAGES-1][0] &&  sck_d;
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
  parameter int BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       session,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi,
  input  logic [7:0] rd_val,
  output logic [7:0] byte0,
  output logic [7:0] byte1,
  output logic [7:0] byte2,
  output logic [7:0] byte3,
  output logic       frame_done,
  output logic       miso
);
  localparam int BITS  = BYTES * 8;
  localparam int CNT_W = $clog2(BITS);

  logic [CNT_W-1:0] bit_cnt, bit_cnt_nxt;
  logic [6:0]       rx, rx_nxt;
  logic [7:0]       tx, tx_nxt;
  logic [7:0]       b0_nxt, b1_nxt, b2_nxt, b3_nxt;
  logic             done_nxt;
  logic [1:0]       idx;
  logic [7:0]       full_byte;

  assign idx       = bit_cnt[CNT_W-1:3];
  assign full_byte = {rx, mosi};

  always_comb begin
    bit_cnt_nxt = bit_cnt;
    rx_nxt      = rx;
    tx_nxt      = tx;
    b0_nxt      = byte0;
    b1_nxt      = byte1;
    b2_nxt      = byte2;
    b3_nxt      = byte3;
    done_nxt    = 1'b0;
    if (!session) begin
      bit_cnt_nxt = '0;
      tx_nxt      = '0;
    end else if (sck_rise) begin
      rx_nxt      = {rx[5:0], mosi};
      bit_cnt_nxt = bit_cnt + 1'b1;
      if (bit_cnt[2:0] == 3'd7) begin
        unique case (idx)
          2'd0: b0_nxt = full_byte;
          2'd1: b1_nxt = full_byte;
          2'd2: b2_nxt = full_byte;
          default: begin
            b3_nxt   = full_byte;
            done_nxt = 1'b1;
          end
        endcase
      end
    end else if (sck_fall) begin
      if (bit_cnt[2:0] == 3'd0) begin
        unique case (idx)
          2'd2:    tx_nxt = byte1;
          2'd3:    tx_nxt = rd_val;
          default: tx_nxt = 8'h00;
        endcase
      end else begin
        tx_nxt = {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx         <= '0;
      tx         <= '0;
      byte0      <= '0;
      byte1      <= '0;
      byte2      <= '0;
      byte3      <= '0;
      frame_done <= 1'b0;
    end else begin
      bit_cnt    <= bit_cnt_nxt;
      rx         <= rx_nxt;
      tx         <= tx_nxt;
      byte0      <= b0_nxt;
      byte1      <= b1_nxt;
      byte2      <= b2_nxt;
      byte3      <= b3_nxt;
      frame_done <= done_nxt;
    end
  end

  assign miso = tx[7];
endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
  parameter int PMEM_DEPTH = 1024,
  parameter int EE_DEPTH   = 128,
  parameter int WR_BUSY    = 700
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic                          we_pm,
  input  logic                          we_hi,
  input  logic [$clog2(PMEM_DEPTH)-1:0] pm_addr,
  input  logic [$clog2(EE_DEPTH)-1:0]   ee_addr,
  input  logic [7:0]                    wdata,
  input  logic                          erase_go,
  output logic                          busy,
  output logic [15:0]                   pm_rdata,
  output logic [7:0]                    ee_rdata
);
  localparam int PA_W = $clog2(PMEM_DEPTH);
  localparam int EA_W = $clog2(EE_DEPTH);
  localparam int BC_W = $clog2(WR_BUSY + 1);

  logic [15:0]     pmem [PMEM_DEPTH];
  logic [7:0]      eemem [EE_DEPTH];
  logic [BC_W-1:0] busy_cnt, busy_cnt_nxt;
  logic [PA_W-1:0] er_idx, er_idx_nxt;
  logic            er_act, er_act_nxt;

  always_comb begin
    er_act_nxt   = er_act;
    er_idx_nxt   = er_idx;
    busy_cnt_nxt = busy_cnt;
    if (erase_go) begin
      er_act_nxt = 1'b1;
      er_idx_nxt = '0;
    end else if (er_act) begin
      er_idx_nxt = er_idx + 1'b1;
      if (er_idx == PA_W'(PMEM_DEPTH - 1)) er_act_nxt = 1'b0;
    end
    if (we)                   busy_cnt_nxt = BC_W'(WR_BUSY);
    else if (busy_cnt != '0)  busy_cnt_nxt = busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_act   <= 1'b0;
      er_idx   <= '0;
      busy_cnt <= '0;
    end else begin
      er_act   <= er_act_nxt;
      er_idx   <= er_idx_nxt;
      busy_cnt <= busy_cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (er_act) begin
      pmem[er_idx] <= 16'hFFFF;
      if (int'(er_idx) < EE_DEPTH) eemem[er_idx[EA_W-1:0]] <= 8'hFF;
    end else if (we) begin
      if (!we_pm)     eemem[ee_addr]       <= wdata;
      else if (we_hi) pmem[pm_addr][15:8]  <= wdata;
      else            pmem[pm_addr][7:0]   <= wdata;
    end
  end

  assign busy     = er_act || (busy_cnt != '0);
  assign pm_rdata = pmem[pm_addr];
  assign ee_rdata = eemem[ee_addr];
endmodule

// File: rtl/isp_prog_slave.sv
module isp_prog_slave #(
  parameter int PMEM_DEPTH = 1024,
  parameter int EE_DEPTH   = 128,
  parameter int WR_BUSY    = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  import isp_pkg::*;

  localparam int PA_W = $clog2(PMEM_DEPTH);
  localparam int EA_W = $clog2(EE_DEPTH);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            sck_rise, sck_fall, session;
  logic [7:0]      b0, b1, b2, b3, rd_val;
  logic            frame_done, busy;
  logic [15:0]     pm_rdata;
  logic [7:0]      ee_rdata;
  logic            en, en_nxt;
  lock_e           lock_lvl, lock_nxt, lock_req;
  logic            mem_we, erase_go;
  logic            is_en, is_erase, is_lock, is_pm_rd, is_pm_wr, is_ee_rd, is_ee_wr;
  logic [15:0]     addr_word;
  logic [PA_W-1:0] pm_addr;
  logic [EA_W-1:0] ee_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  isp_edge_sync u_sync (
    .clk(clk), .rst_n(rst_sync_n), .sck(sck), .prog_rst_n(prog_rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .session(session)
  );

  isp_shifter #(.BYTES(4)) u_shf (
    .clk(clk), .rst_n(rst_sync_n), .session(session),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(mosi), .rd_val(rd_val),
    .byte0(b0), .byte1(b1), .byte2(b2), .byte3(b3),
    .frame_done(frame_done), .miso(miso)
  );

  assign addr_word = {b1, b2};
  assign pm_addr   = addr_word[PA_W-1:0];
  assign ee_addr   = b2[EA_W-1:0];

  isp_mem #(.PMEM_DEPTH(PMEM_DEPTH), .EE_DEPTH(EE_DEPTH), .WR_BUSY(WR_BUSY)) u_mem (
    .clk(clk), .rst_n(rst_sync_n), .we(mem_we), .we_pm(is_pm_wr), .we_hi(b0[3]),
    .pm_addr(pm_addr), .ee_addr(ee_addr), .wdata(b3), .erase_go(erase_go),
    .busy(busy), .pm_rdata(pm_rdata), .ee_rdata(ee_rdata)
  );

  always_comb begin
    is_en    = (b0 == OP_CTRL) && (b1 == KEY_ENABLE);
    is_erase = (b0 == OP_CTRL) && (b1[7:5] == SUB_ERASE);
    is_lock  = (b0 == OP_CTRL) && (b1[7:5] == SUB_LOCK);
    is_pm_rd = ({b0[7:4], b0[2:0]} == OP_PM_RD);
    is_pm_wr = ({b0[7:4], b0[2:0]} == OP_PM_WR);
    is_ee_rd = (b0 == OP_EE_RD);
    is_ee_wr = (b0 == OP_EE_WR);
    if (b1[1])      lock_req = LK_NOVERIFY;
    else if (b1[0]) lock_req = LK_NOPROG;
    else            lock_req = LK_OPEN;
  end

  // reply byte four
  always_comb begin
    rd_val = 8'h00;
    if (en && (is_pm_rd || is_ee_rd)) begin
      if (lock_lvl == LK_NOVERIFY) rd_val = 8'hFF;
      else if (is_ee_rd)           rd_val = ee_rdata;
      else if (b0[3])              rd_val = pm_rdata[15:8];
      else                         rd_val = pm_rdata[7:0];
    end
  end

  always_comb begin
    en_nxt   = en;
    lock_nxt = lock_lvl;
    mem_we   = 1'b0;
    erase_go = 1'b0;
    if (!session) begin
      en_nxt = 1'b0;
    end else if (frame_done) begin
      if (is_en) begin
        en_nxt = 1'b1;
      end else if (en && !busy) begin
        if (is_erase) begin
          erase_go = 1'b1;
          lock_nxt = LK_OPEN;
        end else if (is_lock) begin
          if (lock_req > lock_lvl) lock_nxt = lock_req;
        end else if ((is_pm_wr || is_ee_wr) && lock_lvl == LK_OPEN) begin
          mem_we = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en       <= 1'b0;
      lock_lvl <= LK_OPEN;
    end else begin
      en       <= en_nxt;
      lock_lvl <= lock_nxt;
    end
  end
endmodule

// File: rtl/isp_prog_slave_chk.sv
module isp_prog_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       session,
  input logic       miso,
  input logic       en,
  input logic [1:0] lock_lvl,
  input logic       mem_we,
  input logic       erase_go,
  input logic       busy
);
  AST_MISO_IDLE:     assert property (@(posedge clk) disable iff (!rst_n)
                       !session |=> !miso);                                   // R1
  AST_LOCK_RISES:    assert property (@(posedge clk) disable iff (!rst_n)
                       (lock_lvl < $past(lock_lvl)) |-> $past(erase_go));    // R9
  AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                       (lock_lvl != 2'd0) |-> !mem_we);                      // R10
  AST_WRITE_BUSY:    assert property (@(posedge clk) disable iff (!rst_n)
                       mem_we |=> busy);                                      // R7
  AST_ERASE_BUSY:    assert property (@(posedge clk) disable iff (!rst_n)
                       erase_go |=> busy);                                    // R8
  AST_SESSION_END:   assert property (@(posedge clk) disable iff (!rst_n)
                       !session |=> !en);                                     // R12
endmodule

bind isp_prog_slave isp_prog_slave_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .session(session), .miso(miso), .en(en),
  .lock_lvl(lock_lvl), .mem_we(mem_we), .erase_go(erase_go), .busy(busy)
);

// File: tb/isp_prog_slave_tb_top.sv
module isp_prog_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_rst_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int   total = 0;
  int   bad = 0;
  logic [7:0] r2, r3;

  always #10 clk = ~clk;

  isp_prog_slave #(.PMEM_DEPTH(1024), .EE_DEPTH(128), .WR_BUSY(700)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: mode 0, MSB first, reply sampled before each rising edge
  task automatic xfer(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] d);
    logic [31:0] word;
    logic [31:0] rep;
    word = {a, b, c, d};
    rep  = '0;
    for (int i = 31; i >= 0; i--) begin
      mosi = word[i];
      idle(8);
      rep[i] = miso;
      sck = 1'b1;
      idle(8);
      sck = 1'b0;
    end
    idle(8);
    r2 = rep[15:8];
    r3 = rep[7:0];
  endtask

  task automatic t_reset;
    idle(20);
    chk("R1 miso idle after reset", {7'd0, miso}, 8'h00);
    sck = 1'b1; idle(20); sck = 1'b0; idle(20);
    chk("R1 miso ignores sck outside session", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_pre_enable;
    prog_rst_n = 1'b0; idle(20);
    xfer(8'hA0, 8'h00, 8'h05, 8'h00);
    chk("R4 read before enable", r3, 8'h00);
    chk("R3 echo of byte 2", r2, 8'h00);
  endtask

  task automatic t_enable;
    xfer(8'hAC, 8'h53, 8'h00, 8'h00);
    chk("R3 enable echo 0x53", r2, 8'h53);
  endtask

  task automatic t_erase;
    xfer(8'hAC, 8'h80, 8'h00, 8'h00);
    idle(1200);
    xfer(8'h28, 8'h03, 8'hFF, 8'h00);
    chk("R8 pmem top word high byte erased", r3, 8'hFF);
    xfer(8'hA0, 8'h00, 8'h7F, 8'h00);
    chk("R8 eeprom last byte erased", r3, 8'hFF);
  endtask

  task automatic t_pmem;
    xfer(8'h40, 8'h01, 8'h55, 8'h12); idle(800);
    xfer(8'h48, 8'h01, 8'h55, 8'hAB); idle(800);
    xfer(8'h20, 8'h01, 8'h55, 8'h00);
    chk("R5 pmem low byte", r3, 8'h12);
    xfer(8'h28, 8'h01, 8'h55, 8'h00);
    chk("R5 pmem high byte", r3, 8'hAB);
    chk("R2 echo during read", r2, 8'h01);
    xfer(8'h20, 8'h01, 8'h54, 8'h00);
    chk("R5 neighbour word untouched", r3, 8'hFF);
    xfer(8'h20, 8'h00, 8'h55, 8'h00);
    chk("R5 address bit 8 decoded", r3, 8'hFF);
  endtask

  task automatic t_eeprom;
    xfer(8'hC0, 8'hFF, 8'h33, 8'h5A); idle(800);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R6 eeprom write/read, byte2 ignored", r3, 8'h5A);
  endtask

  task automatic t_busy;
    xfer(8'hC0, 8'h00, 8'h01, 8'h11);
    xfer(8'hC0, 8'h00, 8'h02, 8'h22);
    idle(800);
    xfer(8'hA0, 8'h00, 8'h02, 8'h00);
    chk("R7 write while busy ignored", r3, 8'hFF);
    xfer(8'hA0, 8'h00, 8'h01, 8'h00);
    chk("R7 first write kept", r3, 8'h11);
  endtask

  task automatic t_locks;
    xfer(8'hAC, 8'hE1, 8'h00, 8'h00);
    xfer(8'hC0, 8'h00, 8'h33, 8'h00); idle(800);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R10 write ignored, read works", r3, 8'h5A);
    xfer(8'hAC, 8'hE0, 8'h00, 8'h00);
    xfer(8'hC0, 8'h00, 8'h33, 8'h00); idle(800);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R9 lower level request ignored", r3, 8'h5A);
    xfer(8'hAC, 8'hE2, 8'h00, 8'h00);
    xfer(8'hA0, 8'h00, 8'h01, 8'h00);
    chk("R11 eeprom read masked", r3, 8'hFF);
    xfer(8'h20, 8'h01, 8'h55, 8'h00);
    chk("R11 pmem read masked", r3, 8'hFF);
    xfer(8'hAC, 8'h80, 8'h00, 8'h00);
    idle(1200);
    xfer(8'hC0, 8'h00, 8'h33, 8'h77); idle(800);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R8 erase clears lock", r3, 8'h77);
    xfer(8'h20, 8'h01, 8'h55, 8'h00);
    chk("R8 erase cleared pmem", r3, 8'hFF);
  endtask

  task automatic t_session;
    prog_rst_n = 1'b1; idle(30);
    chk("R1 miso low after session end", {7'd0, miso}, 8'h00);
    prog_rst_n = 1'b0; idle(30);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R12 enable lost on new session", r3, 8'h00);
    xfer(8'hC0, 8'h00, 8'h33, 8'h01);
    xfer(8'hAC, 8'h53, 8'h00, 8'h00);
    idle(800);
    xfer(8'hA0, 8'h00, 8'h33, 8'h00);
    chk("R4 write before enable ignored", r3, 8'h77);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    t_reset();
    t_pre_enable();
    t_enable();
    t_erase();
    t_pmem();
    t_eeprom();
    t_busy();
    t_locks();
    t_session();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule